// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of conversion results leaving a multichannel 12-bit analog-to-digital converter. It checks each result against a programmable window condition. A result arrives as a one-cycle valid strobe together with a 4-bit channel number and 12-bit data. The configuration inputs set four things:
- the comparison mode;
- a low and a high threshold;
- the channel being watched, or a flag that includes every channel;
- a filter count.

A comparison event is reported only after a run of consecutive qualifying results whose length is set by the filter count. The event is held in a sticky flag until it is cleared. An interrupt output presents the flag gated by a mask bit.

The configuration inputs are expected to be driven by a register block elsewhere in the chip. The comparator keeps only its match counter and the event flag.

Top module: `adc_window_cmp`

## Requirements
- R1: With mode code 0 a result qualifies when its data is strictly less than the low threshold.
- R2: With mode code 1 a result qualifies when its data is strictly greater than the high threshold.
- R3: With mode code 2 a result qualifies when low <= data <= high, so both thresholds count as inside.
- R4: With mode code 3 a result qualifies exactly when it would not qualify under mode code 2.
- R5: When the all-channels flag is low, only results whose channel number equals the selected channel are compared. Results on other channels never raise the event.
- R6: When the all-channels flag is high, results on every channel are compared, whatever the selected channel is.
- R7: The event flag is set on the clock edge that samples the (filter+1)-th consecutive qualifying compared result. The match counter then restarts from zero.
- R8: A compared result that does not qualify resets the run of qualifying results to zero.
- R9: When the all-channels flag is low, results on non-selected channels neither advance nor reset the run of qualifying results.
- R10: The event flag stays high until a clear is sampled. An event and a clear sampled on the same edge leave the flag set.
- R11: The interrupt output is high exactly when the event flag is high and the mask input is high. It follows the mask within the same cycle.
- R12: A cycle with the valid strobe low changes neither the run of qualifying results nor the event flag. This holds even when the data and channel inputs would qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result valid strobe |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 12 | Conversion data |
| cfg_mode | input | 2 | Window mode: 0 below, 1 above, 2 inside, 3 outside |
| cfg_low | input | 12 | Low threshold |
| cfg_high | input | 12 | High threshold |
| cfg_chan | input | 4 | Channel compared when the all-channels flag is low |
| cfg_all | input | 1 | Compare results on every channel |
| cfg_filter | input | 2 | Extra consecutive qualifying results needed before an event |
| irq_mask | input | 1 | Interrupt enable for the event flag |
| evt_clear | input | 1 | Clears the sticky event flag |
| evt_flag | output | 1 | Sticky comparison event flag |
| irq | output | 1 | Event flag gated by the mask |

## Verification
The assertions take the configuration inputs as quasi-static. They also assume the low threshold does not exceed the high threshold, since the filter-run and window properties are stated for a stable setup. The stimulus therefore changes mode, thresholds, channel and filter only between scenarios. Before each scenario it applies a reset, so no run of qualifying results carries over from a different setup. Clears and mask changes are the only controls toggled in the middle of a run, and this is where the sticky and gating properties are exercised.

// File: rtl/awc_pkg.sv
package awc_pkg;
  localparam int AWC_DATA_W = 12;
  localparam int AWC_CHAN_W = 4;
  localparam int AWC_FILT_W = 2;

  // Mode encoding: the code values are part of the configuration contract.
  typedef enum logic [1:0] {
    AWC_BELOW   = 2'd0,
    AWC_ABOVE   = 2'd1,
    AWC_INSIDE  = 2'd2,
    AWC_OUTSIDE = 2'd3
  } awc_mode_e;
endpackage

// File: rtl/awc_match.sv
module awc_match #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 4
) (
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        cfg_mode,
  input  logic [DATA_W-1:0] cfg_low,
  input  logic [DATA_W-1:0] cfg_high,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_all,
  output logic              sel,
  output logic              cond
);
  import awc_pkg::*;

  // Inclusive window test: both thresholds count as inside.
  function automatic logic in_window(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] lo,
                                     input logic [DATA_W-1:0] hi);
    return (d >= lo) && (d <= hi);
  endfunction

  function automatic logic window_cond(input logic [1:0] mode,
                                       input logic [DATA_W-1:0] d,
                                       input logic [DATA_W-1:0] lo,
                                       input logic [DATA_W-1:0] hi);
    logic r;
    case (awc_mode_e'(mode))
      AWC_BELOW:   r = (d < lo);
      AWC_ABOVE:   r = (d > hi);
      AWC_INSIDE:  r = in_window(d, lo, hi);
      default:     r = !in_window(d, lo, hi);
    endcase
    return r;
  endfunction

  always_comb begin
    sel  = res_valid && (cfg_all || (res_chan == cfg_chan));
    cond = window_cond(cfg_mode, res_data, cfg_low, cfg_high);
  end
endmodule

// File: rtl/awc_filter.sv
module awc_filter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);
  // The count holds how many qualifying compared results precede this one.
  assign hit = sel && cond && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sel) begin
      if (!cond || hit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/awc_event.sv
module awc_event (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clear,
  input  logic mask,
  output logic flag,
  output logic irq
);
  // Set has priority over clear so that no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (hit)   flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end

  assign irq = flag && mask;
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int DATA_W = awc_pkg::AWC_DATA_W,
  parameter int CHAN_W = awc_pkg::AWC_CHAN_W,
  parameter int FILT_W = awc_pkg::AWC_FILT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        cfg_mode,
  input  logic [DATA_W-1:0] cfg_low,
  input  logic [DATA_W-1:0] cfg_high,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_all,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic              irq_mask,
  input  logic              evt_clear,
  output logic              evt_flag,
  output logic              irq
);
  localparam int CNT_W = FILT_W;

  // Named internal events, brought out for the checker.
  logic             sel_w;
  logic             cond_w;
  logic             hit_w;
  logic [CNT_W-1:0] match_cnt;

  awc_match #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_match (
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_data  (res_data),
    .cfg_mode  (cfg_mode),
    .cfg_low   (cfg_low),
    .cfg_high  (cfg_high),
    .cfg_chan  (cfg_chan),
    .cfg_all   (cfg_all),
    .sel       (sel_w),
    .cond      (cond_w)
  );

  awc_filter #(.CNT_W(CNT_W)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_w),
    .cond  (cond_w),
    .limit (cfg_filter),
    .hit   (hit_w),
    .cnt   (match_cnt)
  );

  awc_event u_event (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_w),
    .clear (evt_clear),
    .mask  (irq_mask),
    .flag  (evt_flag),
    .irq   (irq)
  );
endmodule

// File: rtl/awc_checker.sv
module awc_checker #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             irq_mask,
  input logic             evt_clear,
  input logic             evt_flag,
  input logic             irq,
  input logic             sel,
  input logic             cond,
  input logic             hit,
  input logic [CNT_W-1:0] cnt
);
  // R10: flag holds unless a clear arrives
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !evt_clear) |=> evt_flag);

  // R10: a clear without a simultaneous event drops the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clear && !hit) |=> !evt_flag);

  // R7: the flag only rises after an event
  assert_rise_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_flag && !hit) |=> !evt_flag);

  // R7: an event restarts the run
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));

  // R8: a failing compared result empties the run
  assert_fail_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !cond) |=> (cnt == '0));

  // R9: results outside the comparison leave the run alone
  assert_unselected_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(cnt));

  // R12: nothing is compared without the strobe
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!sel && !hit));

  // R11: the interrupt needs both the flag and the mask
  assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flag && irq_mask));

  assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && irq_mask) |-> irq);
endmodule

bind adc_window_cmp awc_checker #(.CNT_W(CNT_W)) u_awc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .irq_mask  (irq_mask),
  .evt_clear (evt_clear),
  .evt_flag  (evt_flag),
  .irq       (irq),
  .sel       (sel_w),
  .cond      (cond_w),
  .hit       (hit_w),
  .cnt       (match_cnt)
);

// File: tb/adc_window_cmp_tb_top.sv
`timescale 1ns/1ps
module adc_window_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic [1:0]  cfg_mode = '0;
  logic [11:0] cfg_low = '0;
  logic [11:0] cfg_high = '0;
  logic [3:0]  cfg_chan = '0;
  logic        cfg_all = 1'b0;
  logic [1:0]  cfg_filter = '0;
  logic        irq_mask = 1'b0;
  logic        evt_clear = 1'b0;
  logic        evt_flag;
  logic        irq;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_window_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cfg_mode(cfg_mode), .cfg_low(cfg_low),
    .cfg_high(cfg_high), .cfg_chan(cfg_chan), .cfg_all(cfg_all),
    .cfg_filter(cfg_filter), .irq_mask(irq_mask), .evt_clear(evt_clear),
    .evt_flag(evt_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 1'b0; evt_clear = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [1:0] mode, input logic [3:0] ch,
                       input logic all, input logic [1:0] filt);
    reset_dut();
    cfg_mode = mode; cfg_low = 12'd100; cfg_high = 12'd200;
    cfg_chan = ch; cfg_all = all; cfg_filter = filt;
  endtask

  // One valid result; outputs are sampled on the following falling edge.
  task automatic send(input logic [3:0] ch, input logic [11:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    evt_clear = 1'b1;
    @(negedge clk);
    evt_clear = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    check("reset flag", evt_flag, 1'b0);
    check("reset irq", irq, 1'b0);
  endtask

  task automatic t_below();
    setup(2'd0, 4'd1, 1'b0, 2'd0);
    send(4'd1, 12'd100); check("R1 at low", evt_flag, 1'b0);
    send(4'd1, 12'd99);  check("R1 below low", evt_flag, 1'b1);
  endtask

  task automatic t_above();
    setup(2'd1, 4'd1, 1'b0, 2'd0);
    send(4'd1, 12'd200); check("R2 at high", evt_flag, 1'b0);
    send(4'd1, 12'd201); check("R2 above high", evt_flag, 1'b1);
  endtask

  task automatic t_inside();
    setup(2'd2, 4'd1, 1'b0, 2'd0);
    send(4'd1, 12'd201); check("R3 above window", evt_flag, 1'b0);
    send(4'd1, 12'd99);  check("R3 below window", evt_flag, 1'b0);
    send(4'd1, 12'd100); check("R3 low edge", evt_flag, 1'b1);
    pulse_clear();
    send(4'd1, 12'd200); check("R3 high edge", evt_flag, 1'b1);
  endtask

  task automatic t_outside();
    setup(2'd3, 4'd1, 1'b0, 2'd0);
    send(4'd1, 12'd100); check("R4 low edge", evt_flag, 1'b0);
    send(4'd1, 12'd200); check("R4 high edge", evt_flag, 1'b0);
    send(4'd1, 12'd201); check("R4 above", evt_flag, 1'b1);
    pulse_clear();
    send(4'd1, 12'd0);   check("R4 below", evt_flag, 1'b1);
  endtask

  task automatic t_channel();
    setup(2'd0, 4'd5, 1'b0, 2'd0);
    send(4'd3, 12'd0);  check("R5 other channel", evt_flag, 1'b0);
    send(4'd15, 12'd0); check("R5 channel 15", evt_flag, 1'b0);
    send(4'd5, 12'd0);  check("R5 selected channel", evt_flag, 1'b1);
  endtask

  task automatic t_all();
    setup(2'd0, 4'd5, 1'b1, 2'd0);
    send(4'd3, 12'd0); check("R6 all channels", evt_flag, 1'b1);
  endtask

  task automatic t_filter();
    setup(2'd0, 4'd2, 1'b0, 2'd2);
    send(4'd2, 12'd1); check("R7 first match", evt_flag, 1'b0);
    send(4'd2, 12'd1); check("R7 second match", evt_flag, 1'b0);
    send(4'd2, 12'd1); check("R7 third match", evt_flag, 1'b1);
    pulse_clear();
    send(4'd2, 12'd1); check("R7 restart one", evt_flag, 1'b0);
    send(4'd2, 12'd1); check("R7 restart two", evt_flag, 1'b0);
    send(4'd2, 12'd1); check("R7 restart three", evt_flag, 1'b1);
  endtask

  task automatic t_break();
    setup(2'd0, 4'd2, 1'b0, 2'd1);
    send(4'd2, 12'd1);
    send(4'd2, 12'd150); check("R8 broken run", evt_flag, 1'b0);
    send(4'd2, 12'd1);   check("R8 restarted run", evt_flag, 1'b0);
    send(4'd2, 12'd1);   check("R8 run complete", evt_flag, 1'b1);
  endtask

  task automatic t_unselected();
    setup(2'd0, 4'd2, 1'b0, 2'd1);
    send(4'd2, 12'd1);
    send(4'd7, 12'd150); check("R9 failing other channel", evt_flag, 1'b0);
    send(4'd7, 12'd1);   check("R9 matching other channel", evt_flag, 1'b0);
    send(4'd2, 12'd1);   check("R9 run kept", evt_flag, 1'b1);
  endtask

  task automatic t_sticky();
    setup(2'd0, 4'd2, 1'b0, 2'd0);
    send(4'd2, 12'd1);
    send(4'd2, 12'd150); check("R10 holds", evt_flag, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 holds idle", evt_flag, 1'b1);
    pulse_clear();       check("R10 cleared", evt_flag, 1'b0);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 4'd2; res_data = 12'd1; evt_clear = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; evt_clear = 1'b0;
    check("R10 set beats clear", evt_flag, 1'b1);
  endtask

  task automatic t_irq();
    setup(2'd0, 4'd2, 1'b0, 2'd0);
    irq_mask = 1'b1; #1;
    check("R11 no flag", irq, 1'b0);
    send(4'd2, 12'd1); #1;
    check("R11 flag masked on", irq, 1'b1);
    irq_mask = 1'b0; #1;
    check("R11 mask off", irq, 1'b0);
    check("R11 flag kept", evt_flag, 1'b1);
  endtask

  task automatic t_idle();
    setup(2'd0, 4'd2, 1'b0, 2'd1);
    send(4'd2, 12'd1);
    @(negedge clk);
    res_chan = 4'd2; res_data = 12'd1;
    repeat (3) @(negedge clk);
    check("R12 idle no event", evt_flag, 1'b0);
    res_data = 12'd150;
    repeat (2) @(negedge clk);
    send(4'd2, 12'd1); check("R12 run kept", evt_flag, 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_below();
    t_above();
    t_inside();
    t_outside();
    t_channel();
    t_all();
    t_filter();
    t_break();
    t_unselected();
    t_sticky();
    t_irq();
    t_idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule